// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps every in-flight instruction of an out-of-order core in a circular queue. Entries are created in issue order and retired in the same order. When an instruction issues, the block hands back the index of its slot, and that index serves as the rename tag for the instruction's result. Execution units broadcast finished results on a shared result bus that carries this tag. The block captures each result in its slot and marks the slot finished.

Issue logic looks up the source registers of each new instruction. The lookup says whether a register's newest producer is still in flight and, if it is, gives the producer's tag. When that producer has already finished, the lookup also returns the value straight from the queue. Only the oldest slot may retire. A finished register producer then writes the architectural register file, and a finished store writes memory, so memory writes keep program order.

A slot that finishes with the squash flag set stands for a mispredicted branch or a faulting instruction. When it reaches the oldest position, the whole queue and the rename map are cleared and no architectural write takes place. Load units can ask whether an older store that is still pending targets the same address.

Top module: `spec_rob`

## Requirements
- R1: `alloc_tag` always shows the slot the next issue will take. Accepted issues take consecutive tags modulo DEPTH. `alloc_ready` is high whenever the queue holds fewer than DEPTH entries and no flush is in progress. It is low when the queue is full and nothing retires in that cycle.
- R2: On a full queue, an issue in the same cycle as a retirement is accepted. It takes the tag of the slot that is retiring.
- R3: A result-bus beat whose `cdb_tag` names an occupied slot stores `cdb_value` and the squash flag in that slot. It marks the slot finished from the next cycle on.
- R4: A source lookup reports busy, with the tag of the newest in-flight producer of that register. It also raises `src_ready` and returns that producer's value once the producer has finished, for as long as it has not retired.
- R5: Retirement happens only from the oldest slot, one slot per cycle, and only after that slot has finished. A younger finished slot waits. A retiring ALU (kind 0) or load (kind 1) pulses `rf_we` with its register number and value.
- R6: A store (kind 2) pulses `mem_we` with its address and value only when it retires from the oldest slot, and never while older slots are unfinished.
- R7: When a producer retires, its register leaves the busy state only if no younger in-flight instruction targets the same register. Otherwise the lookup keeps the younger tag.
- R8: When a slot with the squash flag reaches the oldest position, `flush` pulses. In that cycle `rf_we`, `mem_we` and `alloc_ready` are low. All slots are discarded, with no later write from them. Every register lookup reads not busy, and the next issue takes tag 0.
- R9: `ld_conflict` is high when a slot older than `ld_tag` holds a store whose address equals `ld_addr`. Stores younger than the load, stores with other addresses, and stores that have retired do not count.
- R10: A branch (kind 3) that finishes without the squash flag retires with no register write, no memory write and no flush. Tag numbering continues without a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Issue request |
| alloc_kind | input | 2 | 0 ALU, 1 load, 2 store, 3 branch |
| alloc_dreg | input | RW | Destination register (ALU, load) |
| alloc_addr | input | AW | Store target address |
| alloc_ready | output | 1 | Issue accepted this cycle if requested |
| alloc_tag | output | TW | Slot taken by the next issue |
| cdb_valid | input | 1 | Result bus beat |
| cdb_tag | input | TW | Slot the result belongs to |
| cdb_value | input | DW | Result value or store data |
| cdb_squash | input | 1 | Mispredict or fault marker |
| src_reg | input | NSRC*RW | Registers looked up, one field per port |
| src_busy | output | NSRC | Register has an in-flight producer |
| src_tag | output | NSRC*TW | Tag of the newest producer |
| src_ready | output | NSRC | That producer has finished |
| src_value | output | NSRC*DW | That producer's value |
| ld_addr | input | AW | Load address for conflict query |
| ld_tag | input | TW | Slot of the querying load |
| ld_conflict | output | 1 | Older pending store matches |
| rf_we | output | 1 | Register file write |
| rf_waddr | output | RW | Register written |
| rf_wdata | output | DW | Value written |
| mem_we | output | 1 | Memory write from a retiring store |
| mem_waddr | output | AW | Store address |
| mem_wdata | output | DW | Store data |
| flush | output | 1 | Squash of all in-flight slots |

## Verification
The assertions watch the cycle-level rules on every cycle. Issue must be accepted when there is room and refused on a full queue with no retirement. A flush must come alone and leave the queue empty. The occupancy must follow issues minus retirements, and at most one write or flush may happen per cycle. Some properties only the directed scenarios can show. These are the order and values of register and memory writes, the rename map keeping a younger tag, the way a store's age sets the load conflict answer, the tag wrap on a full queue, and the restart of tag numbering after a squash.

// File: rtl/rob_pkg.sv
// rob_pkg: types shared by the reorder buffer and its sub-blocks.
// Assumes the 2-bit kind code is the issue-side encoding.
package rob_pkg;

    typedef enum logic [1:0] {
        OP_ALU    = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STORE  = 2'd2,
        OP_BRANCH = 2'd3
    } op_kind_e;

    // True for kinds that produce an architectural register value.
    function automatic logic writes_reg(op_kind_e k);
        return (k == OP_ALU) || (k == OP_LOAD);
    endfunction

endpackage

// File: rtl/rob_ptrs.sv
// rob_ptrs: head, tail and occupancy of the circular slot array.
// Assumes DEPTH is a power of two so pointers wrap by overflow;
// push is never asserted when full unless pop is asserted too.
module rob_ptrs #(
    parameter int DEPTH = 8,
    localparam int TW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clear,
    output logic [TW-1:0] head,
    output logic [TW-1:0] tail,
    output logic [CW-1:0] count,
    output logic          full
);

    // Advance pointers and occupancy; clear restarts both at slot 0.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= tail + TW'(1);
            if (pop)  head <= head + TW'(1);
            count <= count + CW'(push) - CW'(pop);
        end
    end

    assign full = (count == CW'(DEPTH));

endmodule

// File: rtl/rob_rename.sv
// rob_rename: per-register map to the newest in-flight producer tag.
// Assumes set and clear never target a flushed cycle (flush wins).
// A set to a register overrides a same-cycle clear of that register.
module rob_rename #(
    parameter int NREG = 16,
    parameter int TW   = 3,
    parameter int NSRC = 2,
    localparam int RW  = $clog2(NREG)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               set_en,
    input  logic [RW-1:0]      set_reg,
    input  logic [TW-1:0]      set_tag,
    input  logic               clr_en,
    input  logic [RW-1:0]      clr_reg,
    input  logic [TW-1:0]      clr_tag,
    input  logic [NSRC*RW-1:0] q_reg,
    output logic [NSRC-1:0]    q_busy,
    output logic [NSRC*TW-1:0] q_tag
);

    logic          busy_q [NREG];
    logic [TW-1:0] tag_q  [NREG];

    for (genvar r = 0; r < NREG; r++) begin : g_map
        localparam logic [RW-1:0] REG_ID = RW'(r);
        // Track the newest producer of this register.
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                busy_q[r] <= 1'b0;
                tag_q[r]  <= '0;
            end else if (set_en && set_reg == REG_ID) begin
                busy_q[r] <= 1'b1;
                tag_q[r]  <= set_tag;
            end else if (clr_en && clr_reg == REG_ID && tag_q[r] == clr_tag) begin
                busy_q[r] <= 1'b0;
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_look
        logic [RW-1:0] idx;
        // Read the map entry named by this lookup port.
        always_comb begin
            idx = q_reg[s*RW +: RW];
            q_busy[s]          = busy_q[idx];
            q_tag[s*TW +: TW]  = tag_q[idx];
        end
    end

endmodule

// File: rtl/rob_store_check.sv
// rob_store_check: flags an older occupied store slot whose address
// equals the queried load address. Age is distance from the head,
// which assumes DEPTH is a power of two.
module rob_store_check #(
    parameter int DEPTH = 8,
    parameter int AW    = 16,
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] is_store,
    input  logic [AW-1:0]    slot_addr [DEPTH],
    input  logic [TW-1:0]    head,
    input  logic [AW-1:0]    q_addr,
    input  logic [TW-1:0]    q_tag,
    output logic             conflict
);

    logic [TW-1:0]    q_age;
    logic [DEPTH-1:0] hit;

    assign q_age = q_tag - head;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        localparam logic [TW-1:0] SLOT = TW'(i);
        logic [TW-1:0] age;
        // Match when this slot is an older store to the same address.
        always_comb begin
            age    = SLOT - head;
            hit[i] = is_store[i] && (slot_addr[i] == q_addr) && (age < q_age);
        end
    end

    assign conflict = |hit;

endmodule

// File: rtl/spec_rob.sv
// spec_rob: speculative reorder buffer. Allocates one slot per cycle at
// the tail, captures result-bus beats by slot tag, serves operand
// lookups, retires the head slot once finished, and squashes all slots
// when a marked slot retires. Assumes DEPTH is a power of two and that
// the result bus only names slots that are occupied.
module spec_rob
    import rob_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NREG  = 16,
    parameter int DW    = 32,
    parameter int AW    = 16,
    parameter int NSRC  = 2,
    localparam int TW   = $clog2(DEPTH),
    localparam int RW   = $clog2(NREG),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc_valid,
    input  logic [1:0]         alloc_kind,
    input  logic [RW-1:0]      alloc_dreg,
    input  logic [AW-1:0]      alloc_addr,
    output logic               alloc_ready,
    output logic [TW-1:0]      alloc_tag,
    input  logic               cdb_valid,
    input  logic [TW-1:0]      cdb_tag,
    input  logic [DW-1:0]      cdb_value,
    input  logic               cdb_squash,
    input  logic [NSRC*RW-1:0] src_reg,
    output logic [NSRC-1:0]    src_busy,
    output logic [NSRC*TW-1:0] src_tag,
    output logic [NSRC-1:0]    src_ready,
    output logic [NSRC*DW-1:0] src_value,
    input  logic [AW-1:0]      ld_addr,
    input  logic [TW-1:0]      ld_tag,
    output logic               ld_conflict,
    output logic               rf_we,
    output logic [RW-1:0]      rf_waddr,
    output logic [DW-1:0]      rf_wdata,
    output logic               mem_we,
    output logic [AW-1:0]      mem_waddr,
    output logic [DW-1:0]      mem_wdata,
    output logic               flush
);

    // Slot state.
    logic [DEPTH-1:0] vld_q;
    logic [DEPTH-1:0] done_q;
    logic [DEPTH-1:0] squash_q;
    logic [DEPTH-1:0] store_q;
    op_kind_e         kind_q  [DEPTH];
    logic [RW-1:0]    dreg_q  [DEPTH];
    logic [AW-1:0]    addr_q  [DEPTH];
    logic [DW-1:0]    value_q [DEPTH];

    logic [TW-1:0] head, tail;
    logic [CW-1:0] count;
    logic          full;
    logic          commit_fire, alloc_fire, redirect;
    op_kind_e      head_kind, new_kind;

    assign new_kind    = op_kind_e'(alloc_kind);
    assign head_kind   = kind_q[head];
    assign commit_fire = vld_q[head] && done_q[head];
    assign redirect    = commit_fire && squash_q[head];
    assign alloc_ready = !redirect && (!full || commit_fire);
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail;

    rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (alloc_fire),
        .pop   (commit_fire && !redirect),
        .clear (redirect),
        .head  (head),
        .tail  (tail),
        .count (count),
        .full  (full)
    );

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam logic [TW-1:0] SLOT = TW'(i);
        logic take, fill, retire;
        assign take   = alloc_fire && (tail == SLOT);
        assign fill   = cdb_valid && (cdb_tag == SLOT) && vld_q[i];
        assign retire = commit_fire && (head == SLOT);

        // Slot life cycle: allocate, capture result, retire or squash.
        always_ff @(posedge clk) begin
            if (!rst_n || redirect) begin
                vld_q[i]    <= 1'b0;
                done_q[i]   <= 1'b0;
                squash_q[i] <= 1'b0;
                store_q[i]  <= 1'b0;
            end else begin
                if (retire) begin
                    vld_q[i]   <= 1'b0;
                    store_q[i] <= 1'b0;
                end
                if (fill) begin
                    done_q[i]   <= 1'b1;
                    squash_q[i] <= cdb_squash;
                end
                if (take) begin
                    vld_q[i]    <= 1'b1;
                    done_q[i]   <= 1'b0;
                    squash_q[i] <= 1'b0;
                    store_q[i]  <= (new_kind == OP_STORE);
                end
            end
        end

        // Payload fields; written on allocation and on result capture.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                kind_q[i]  <= OP_ALU;
                dreg_q[i]  <= '0;
                addr_q[i]  <= '0;
                value_q[i] <= '0;
            end else begin
                if (take) begin
                    kind_q[i] <= new_kind;
                    dreg_q[i] <= alloc_dreg;
                    addr_q[i] <= alloc_addr;
                end
                if (fill) value_q[i] <= cdb_value;
            end
        end
    end

    // Architectural updates from the head slot.
    assign rf_we     = commit_fire && !redirect && writes_reg(head_kind);
    assign rf_waddr  = dreg_q[head];
    assign rf_wdata  = value_q[head];
    assign mem_we    = commit_fire && !redirect && (head_kind == OP_STORE);
    assign mem_waddr = addr_q[head];
    assign mem_wdata = value_q[head];
    assign flush     = redirect;

    logic [NSRC*TW-1:0] map_tag;
    logic [NSRC-1:0]    map_busy;

    rob_rename #(.NREG(NREG), .TW(TW), .NSRC(NSRC)) u_rename (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (redirect),
        .set_en  (alloc_fire && writes_reg(new_kind)),
        .set_reg (alloc_dreg),
        .set_tag (tail),
        .clr_en  (rf_we),
        .clr_reg (dreg_q[head]),
        .clr_tag (head),
        .q_reg   (src_reg),
        .q_busy  (map_busy),
        .q_tag   (map_tag)
    );

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        logic [TW-1:0] t;
        // Forward a finished producer's value out of its slot.
        always_comb begin
            t = map_tag[s*TW +: TW];
            src_busy[s]            = map_busy[s];
            src_tag[s*TW +: TW]    = t;
            src_ready[s]           = map_busy[s] && done_q[t];
            src_value[s*DW +: DW]  = value_q[t];
        end
    end

    rob_store_check #(.DEPTH(DEPTH), .AW(AW)) u_stchk (
        .is_store  (store_q & vld_q),
        .slot_addr (addr_q),
        .head      (head),
        .q_addr    (ld_addr),
        .q_tag     (ld_tag),
        .conflict  (ld_conflict)
    );

endmodule

// File: rtl/spec_rob_chk.sv
// spec_rob_chk: cycle rules of the reorder buffer, bound to spec_rob.
// Observes ports plus the occupancy count and retirement strobe.
module spec_rob_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic          commit_fire,
    input logic          rf_we,
    input logic          mem_we,
    input logic          flush,
    input logic [CW-1:0] count
);

    a_r1_room_accepts: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && count < CW'(DEPTH)) |-> alloc_ready);

    a_r1_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !commit_fire) |-> !alloc_ready);

    a_r8_flush_alone: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!rf_we && !mem_we && !alloc_ready));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    a_r2_count_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (count == CW'($past(count) + CW'($past(alloc_valid && alloc_ready))
                                 - CW'($past(commit_fire)))));

    a_r5_retire_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        commit_fire |-> (count != '0));

    a_r5_one_update: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_we, mem_we, flush}));

    a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

endmodule

bind spec_rob spec_rob_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .commit_fire (commit_fire),
    .rf_we       (rf_we),
    .mem_we      (mem_we),
    .flush       (flush),
    .count       (count)
);

// File: tb/spec_rob_test.sv
// spec_rob_test: directed scenarios for spec_rob, one task each.
module spec_rob_test;

    localparam int DEPTH = 8;
    localparam int TW = 3, RW = 4, DW = 32, AW = 16, NSRC = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_valid = 0; logic [1:0] alloc_kind = 0;
    logic [RW-1:0] alloc_dreg = 0; logic [AW-1:0] alloc_addr = 0;
    logic alloc_ready; logic [TW-1:0] alloc_tag;
    logic cdb_valid = 0; logic [TW-1:0] cdb_tag = 0;
    logic [DW-1:0] cdb_value = 0; logic cdb_squash = 0;
    logic [NSRC*RW-1:0] src_reg = 0;
    logic [NSRC-1:0] src_busy, src_ready;
    logic [NSRC*TW-1:0] src_tag; logic [NSRC*DW-1:0] src_value;
    logic [AW-1:0] ld_addr = 0; logic [TW-1:0] ld_tag = 0; logic ld_conflict;
    logic rf_we, mem_we, flush;
    logic [RW-1:0] rf_waddr; logic [DW-1:0] rf_wdata, mem_wdata; logic [AW-1:0] mem_waddr;

    spec_rob uut (.*);

    always #5 clk = ~clk;

    int n_chk = 0, n_bad = 0, exp_tail = 0;
    int lg_n = 0; int lg_k [64]; int lg_a [64]; int lg_d [64];
    bit finished = 0;

    // Record every architectural update, sampled mid-cycle.
    always @(negedge clk) if (rst_n && lg_n < 64) begin
        if (rf_we)  begin lg_k[lg_n] = 0; lg_a[lg_n] = rf_waddr;  lg_d[lg_n] = rf_wdata;  lg_n++; end
        if (mem_we) begin lg_k[lg_n] = 1; lg_a[lg_n] = mem_waddr; lg_d[lg_n] = mem_wdata; lg_n++; end
        if (flush)  begin lg_k[lg_n] = 2; lg_a[lg_n] = 0;         lg_d[lg_n] = 0;         lg_n++; end
    end

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_alloc(int kind, int dreg, int addr, output int tag, output bit rdy);
        @(negedge clk);
        alloc_valid = 1; alloc_kind = 2'(kind); alloc_dreg = RW'(dreg); alloc_addr = AW'(addr);
        #1 rdy = alloc_ready; tag = alloc_tag;
        @(posedge clk); #1 alloc_valid = 0;
        if (rdy) exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic do_cdb(int tag, int val, bit sq);
        @(negedge clk);
        cdb_valid = 1; cdb_tag = TW'(tag); cdb_value = DW'(val); cdb_squash = sq;
        @(posedge clk); #1 cdb_valid = 0; cdb_squash = 0;
    endtask

    task automatic look(int r0, int r1);
        @(negedge clk);
        src_reg = {RW'(r1), RW'(r0)};
        #1;
    endtask

    task automatic query(int addr, int tag, output bit c);
        @(negedge clk);
        ld_addr = AW'(addr); ld_tag = TW'(tag);
        #1 c = ld_conflict;
    endtask

    task automatic t_reset();
        check("R1 ready after reset", alloc_ready, 1);
        check("R1 tag after reset", alloc_tag, 0);
        check("R5 no write after reset", {rf_we, mem_we, flush}, 0);
        check("R9 no conflict after reset", ld_conflict, 0);
    endtask

    task automatic t_order();
        int t0, t1, t2; bit r;
        lg_n = 0;
        do_alloc(0, 1, 0, t0, r); check("R1 first tag", t0, 0);
        do_alloc(0, 2, 0, t1, r); check("R1 second tag", t1, 1);
        do_alloc(1, 3, 0, t2, r); check("R1 third tag", t2, 2);
        look(3, 1);
        check("R4 busy", src_busy, 2'b11);
        check("R4 newest tag", src_tag[2:0], t2);
        check("R4 not ready before result", src_ready, 0);
        do_cdb(t2, 'h333, 0); tick(1);
        check("R5 younger finished waits", lg_n, 0);
        look(3, 1);
        check("R3 done flag", src_ready[0], 1);
        check("R4 forwarded value", src_value[31:0], 'h333);
        do_cdb(t0, 'h111, 0); tick(2);
        check("R5 head retires", lg_n, 1);
        check("R5 reg written", lg_a[0], 1);
        check("R5 value written", lg_d[0], 'h111);
        do_cdb(t1, 'h222, 0); tick(3);
        check("R5 in order count", lg_n, 3);
        check("R5 order reg", {lg_a[1], lg_a[2]}, {32'd2, 32'd3});
        check("R5 order value", lg_d[2], 'h333);
        look(3, 1);
        check("R7 cleared after retire", src_busy, 0);
    endtask

    task automatic t_rename();
        int ta, tb; bit r;
        lg_n = 0;
        do_alloc(0, 5, 0, ta, r);
        do_alloc(0, 5, 0, tb, r);
        look(5, 5); check("R4 newest of two", src_tag[2:0], tb);
        do_cdb(ta, 'hA, 0); tick(2);
        check("R5 older retired", lg_d[0], 'hA);
        look(5, 5);
        check("R7 younger keeps busy", src_busy[0], 1);
        check("R7 younger tag kept", src_tag[2:0], tb);
        do_cdb(tb, 'hB, 0); tick(2);
        look(5, 5); check("R7 last retire clears", src_busy[0], 0);
    endtask

    task automatic t_store();
        int l1, s, l2; bit r, c;
        lg_n = 0;
        do_alloc(1, 6, 0, l1, r);
        do_alloc(2, 0, 'h40, s, r);
        do_alloc(1, 8, 0, l2, r);
        query('h40, l2, c); check("R9 older store matches", c, 1);
        query('h44, l2, c); check("R9 other address", c, 0);
        query('h40, l1, c); check("R9 younger store ignored", c, 0);
        do_cdb(s, 'hDEAD, 0); tick(2);
        check("R6 store waits for head", lg_n, 0);
        do_cdb(l1, 'h66, 0); tick(3);
        check("R6 writes count", lg_n, 2);
        check("R6 load first", {lg_k[0], lg_a[0], lg_d[0]}, {32'd0, 32'd6, 32'h66});
        check("R6 store write", {lg_k[1], lg_a[1], lg_d[1]}, {32'd1, 32'h40, 32'hDEAD});
        query('h40, l2, c); check("R9 retired store gone", c, 0);
        do_cdb(l2, 'h88, 0); tick(2);
    endtask

    task automatic t_full();
        int h, tg; bit r;
        lg_n = 0; h = exp_tail;
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(0, 9, 0, tg, r);
            check("R1 fill accepted", r, 1);
        end
        do_alloc(0, 9, 0, tg, r); check("R1 full refuses", r, 0);
        do_cdb(h, 'h900, 0);
        do_alloc(0, 10, 0, tg, r);
        check("R2 alloc with retire on full", r, 1);
        check("R2 reuses retiring slot", tg, h);
        for (int i = 1; i < DEPTH; i++) do_cdb((h + i) % DEPTH, 'h900 + i, 0);
        do_cdb(h, 'hA00, 0); tick(3);
        check("R2 all retired", lg_n, DEPTH + 1);
        check("R2 last value", lg_d[DEPTH], 'hA00);
    endtask

    task automatic t_flush();
        int b, ta, ts, tg; bit r;
        lg_n = 0;
        do_alloc(3, 0, 0, b, r);
        do_alloc(0, 7, 0, ta, r);
        do_alloc(2, 0, 'h80, ts, r);
        do_cdb(ta, 'h77, 0);
        do_cdb(ts, 'h55, 0);
        do_cdb(b, 0, 1);
        do_alloc(0, 1, 0, tg, r);
        check("R8 no issue during flush", r, 0);
        tick(2);
        check("R8 only flush logged", lg_n, 1);
        check("R8 flush kind", lg_k[0], 2);
        look(7, 7); check("R8 rename cleared", src_busy[0], 0);
        exp_tail = 0;
        do_alloc(0, 2, 0, tg, r); check("R8 tags restart", tg, 0);
        do_cdb(tg, 'h12, 0); tick(2);
        lg_n = 0;
        do_alloc(3, 0, 0, b, r);
        check("R10 tags continue", b, 1);
        do_cdb(b, 0, 0); tick(2);
        check("R10 branch no update", lg_n, 0);
        do_alloc(0, 3, 0, tg, r); check("R10 next tag", tg, exp_tail == 0 ? DEPTH - 1 : exp_tail - 1);
        do_cdb(tg, 'h3, 0); tick(2);
        check("R10 later work retires", lg_n, 1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_order();
        t_rename();
        t_store();
        t_full();
        t_flush();
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

endmodule